// File: doc/BRIEF.md
# Home Computer Keyboard and Tape I/O Port

This block is the one I/O port of a small 8-bit home computer, as seen from a CPU-style bus with a 16-bit address, an 8-bit data path and active-low request, read and write strobes. Only address bit 0 is decoded, so every even I/O address reaches the port. A read returns the state of a 40-key matrix keyboard and the tape input level. The keyboard is grouped as eight half-rows of five keys, and the CPU selects which half-rows to scan by pulling bits of the upper address byte low. When several half-rows are selected, a column reads low if its key is down in any of them.

A write sets three output latches: a 3-bit border colour, the tape output (MIC) bit and the speaker bit. The upper address byte plays no part in writes. The read path is combinational and is qualified by a data-valid flag. The write latches update on the rising clock edge of a cycle in which a qualifying write is presented.

Top module: `hc_io_port`

## Requirements
- R1: The port is selected when `iorq_n` is low and `addr[0]` is 0. Address bits 7..1 play no part in selection.
- R2: On a read, half-row k (k = 0..7) is scanned exactly when `addr[8+k]` is 0. A key in a half-row that is not scanned has no effect on the result.
- R3: Key k*5+j of `keys` (1 = pressed) belongs to half-row k and column j. `dout[j]` (j = 0..4) is 0 when that column's key is pressed in at least one scanned half-row, and 1 otherwise. With no half-row scanned, bits 4..0 read 1.
- R4: During a valid read, `dout[6]` equals `ear`, and the unused bits `dout[5]` and `dout[7]` read 0.
- R5: `dout_valid` is 1 only while `iorq_n`, `rd_n` and `addr[0]` are all 0. While `dout_valid` is 0, `dout` is 8'hFF.
- R6: At a rising clock edge where `iorq_n`, `wr_n` and `addr[0]` are all 0, `border` takes `din[2:0]`, `mic` takes `din[3]` and `spk` takes `din[4]`. `addr[15:8]` and `din[7:5]` are ignored.
- R7: At any other rising edge, `border`, `mic` and `spk` hold their values. This covers writes to odd addresses, writes with `iorq_n` high, and read-only cycles.
- R8: While `rst_n` is low, `border`, `mic` and `spk` are 0.
- R9: With keys 0 (row 0, col 0), 14 (row 2, col 4) and 26 (row 5, col 1) pressed, a read of address 16'hDEFE with `ear` at 0 returns 8'h1C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output latches |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 16 | I/O address; bit 0 decodes the port, bits 15..8 scan half-rows |
| din | input | 8 | Write data from the CPU |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| keys | input | 40 | Key-pressed vector, bit k*5+j = row k column j, 1 = pressed |
| ear | input | 1 | Tape input level |
| border | output | 3 | Border colour latch |
| mic | output | 1 | Tape output latch |
| spk | output | 1 | Speaker latch |
| dout | output | 8 | Read data byte, 8'hFF when not valid |
| dout_valid | output | 1 | High while a read of the port is in progress |

## Verification
A keyboard read and a latch update can fall in the same cycle when `rd_n` and `wr_n` are both held low with `iorq_n`. Nothing in the decode keeps the two apart. The bench provokes this with a single cycle that presents a half-row pattern and write data together. It then judges both halves: the read byte is compared with the expected key merge during that cycle, and the border, MIC and speaker values are compared after the edge. This confirms that neither path masks or corrupts the other.

// File: rtl/hc_io_pkg.sv
package hc_io_pkg;

  localparam int HC_ROWS  = 8;
  localparam int HC_COLS  = 5;
  localparam int HC_DW    = 8;
  localparam int HC_BRD_W = 3;

  // Data-bus positions shared by the read packer and the write latch
  localparam int HC_EAR_BIT = 6;
  localparam int HC_MIC_BIT = 3;
  localparam int HC_SPK_BIT = 4;

  // Assemble the returned byte: columns low, tape level, unused bits at 0
  function automatic logic [HC_DW-1:0] hc_pack_read(
    input logic [HC_COLS-1:0] cols,
    input logic               ear_lvl
  );
    logic [HC_DW-1:0] b;
    b = '0;
    b[HC_COLS-1:0] = cols;
    b[HC_EAR_BIT]  = ear_lvl;
    return b;
  endfunction

  // AND a set of active-low column terms together
  function automatic logic [HC_COLS-1:0] hc_and_rows(
    input logic [HC_ROWS*HC_COLS-1:0] terms
  );
    logic [HC_COLS-1:0] acc;
    acc = '1;
    for (int r = 0; r < HC_ROWS; r++) begin
      acc &= terms[r*HC_COLS +: HC_COLS];
    end
    return acc;
  endfunction

endpackage

// File: rtl/hc_port_decode.sv
module hc_port_decode (
  input  logic sel_bit,
  input  logic iorq_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic port_hit,
  output logic rd_hit,
  output logic wr_hit
);

  always_comb begin
    port_hit = ~iorq_n & ~sel_bit;
    rd_hit   = port_hit & ~rd_n;
    wr_hit   = port_hit & ~wr_n;
  end

endmodule

// File: rtl/hc_key_matrix.sv
module hc_key_matrix
  import hc_io_pkg::*;
#(
  parameter int ROWS = HC_ROWS,
  parameter int COLS = HC_COLS
) (
  input  logic [ROWS-1:0]      row_sel_n,
  input  logic [ROWS*COLS-1:0] keys,
  output logic [COLS-1:0]      cols_n
);

  localparam int NKEYS = ROWS * COLS;

  logic [NKEYS-1:0] row_terms;

  // One active-low term per half-row; unscanned rows contribute all ones
  for (genvar g = 0; g < ROWS; g++) begin : g_row
    assign row_terms[g*COLS +: COLS] =
      row_sel_n[g] ? {COLS{1'b1}} : ~keys[g*COLS +: COLS];
  end

  assign cols_n = hc_and_rows(row_terms);

endmodule

// File: rtl/hc_out_latch.sv
module hc_out_latch
  import hc_io_pkg::*;
#(
  parameter int BRD_W = HC_BRD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BRD_W-1:0] brd_d,
  input  logic             mic_d,
  input  logic             spk_d,
  output logic [BRD_W-1:0] brd_q,
  output logic             mic_q,
  output logic             spk_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brd_q <= '0;
      mic_q <= 1'b0;
      spk_q <= 1'b0;
    end else if (load) begin
      brd_q <= brd_d;
      mic_q <= mic_d;
      spk_q <= spk_d;
    end
  end

endmodule

// File: rtl/hc_io_port.sv
module hc_io_port
  import hc_io_pkg::*;
#(
  parameter int ROWS  = HC_ROWS,
  parameter int COLS  = HC_COLS,
  parameter int BRD_W = HC_BRD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [15:0]          addr,
  input  logic [HC_DW-1:0]     din,
  input  logic                 iorq_n,
  input  logic                 rd_n,
  input  logic                 wr_n,
  input  logic [ROWS*COLS-1:0] keys,
  input  logic                 ear,
  output logic [BRD_W-1:0]     border,
  output logic                 mic,
  output logic                 spk,
  output logic [HC_DW-1:0]     dout,
  output logic                 dout_valid
);

  localparam int ROW_LSB = 8;

  // Named internal events, observed by the bound checker
  logic            port_hit;
  logic            rd_hit;
  logic            wr_hit;
  logic [COLS-1:0] cols_n;
  logic [HC_DW-1:0] rd_byte;

  // Address bits 7..1 and data bits 7..5 are deliberately not decoded
  logic unused_bits;
  assign unused_bits = ^{addr[7:1], din[7:5]};

  hc_port_decode u_dec (
    .sel_bit  (addr[0]),
    .iorq_n   (iorq_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .port_hit (port_hit),
    .rd_hit   (rd_hit),
    .wr_hit   (wr_hit)
  );

  hc_key_matrix #(
    .ROWS (ROWS),
    .COLS (COLS)
  ) u_kbd (
    .row_sel_n (addr[ROW_LSB +: ROWS]),
    .keys      (keys),
    .cols_n    (cols_n)
  );

  assign rd_byte    = hc_pack_read(cols_n, ear);
  assign dout       = rd_hit ? rd_byte : {HC_DW{1'b1}};
  assign dout_valid = rd_hit;

  hc_out_latch #(
    .BRD_W (BRD_W)
  ) u_lat (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (wr_hit),
    .brd_d (din[BRD_W-1:0]),
    .mic_d (din[HC_MIC_BIT]),
    .spk_d (din[HC_SPK_BIT]),
    .brd_q (border),
    .mic_q (mic),
    .spk_q (spk)
  );

endmodule

// File: rtl/hc_io_port_chk.sv
module hc_io_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input logic [7:0]  din,
  input logic        iorq_n,
  input logic        rd_n,
  input logic        ear,
  input logic [2:0]  border,
  input logic        mic,
  input logic        spk,
  input logic [7:0]  dout,
  input logic        dout_valid,
  input logic        port_hit,
  input logic        wr_hit
);

  // R1: a valid read implies the decoded select conditions
  a_r1_decode: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> (port_hit && !addr[0] && !iorq_n));

  // R3: nothing scanned means all columns read released
  a_r3_no_rows: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && (&addr[15:8])) |-> (dout[4:0] == 5'h1F));

  // R4: tape level and unused bits during a read
  a_r4_ear_bit: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> (dout[6] == ear && !dout[5] && !dout[7]));

  // R5: idle bus reads all ones, and validity needs the read strobe
  a_r5_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_valid |-> (dout == 8'hFF));
  a_r5_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> !rd_n);

  // R6: latches follow the written byte one edge later
  a_r6_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (border == $past(din[2:0]) && mic == $past(din[3])
                && spk == $past(din[4])));

  // R7: no qualifying write, no change
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> ($stable(border) && $stable(mic) && $stable(spk)));

endmodule

bind hc_io_port hc_io_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr       (addr),
  .din        (din),
  .iorq_n     (iorq_n),
  .rd_n       (rd_n),
  .ear        (ear),
  .border     (border),
  .mic        (mic),
  .spk        (spk),
  .dout       (dout),
  .dout_valid (dout_valid),
  .port_hit   (port_hit),
  .wr_hit     (wr_hit)
);

// File: tb/tb_hc_io_port.sv
module tb_hc_io_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'hFFFF;
  logic [7:0]  din = 8'h00;
  logic        iorq_n = 1'b1;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [39:0] keys = '0;
  logic        ear = 1'b0;
  logic [2:0]  border;
  logic        mic;
  logic        spk;
  logic [7:0]  dout;
  logic        dout_valid;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  hc_io_port dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .keys(keys), .ear(ear),
    .border(border), .mic(mic), .spk(spk), .dout(dout), .dout_valid(dout_valid)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Model of a read: scan every key by its index
  function automatic logic [7:0] model_read(input logic [39:0] k, input logic [15:0] a,
                                            input logic e);
    logic [7:0] b;
    b = 8'h1F;
    for (int i = 0; i < 40; i++) begin
      if (k[i] && !a[8 + i / 5]) b[i % 5] = 1'b0;
    end
    b[6] = e;
    return b;
  endfunction

  task automatic idle_bus();
    @(negedge clk);
    iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; addr = 16'hFFFF;
  endtask

  task automatic do_read(input logic [15:0] a);
    @(negedge clk);
    addr = a; iorq_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1;
    #2;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d,
                          input logic iq, input logic w);
    @(negedge clk);
    addr = a; din = d; iorq_n = iq; wr_n = w; rd_n = 1'b1;
    @(posedge clk);
    #2;
    idle_bus();
  endtask

  task automatic t_reset();
    #2;
    check("R8 border", {13'd0, border}, 16'd0);
    check("R8 mic/spk", {14'd0, mic, spk}, 16'd0);
    check("R5 idle valid", {15'd0, dout_valid}, 16'd0);
    check("R5 idle dout", {8'd0, dout}, 16'h00FF);
  endtask

  task automatic t_example();
    keys = '0; keys[0] = 1'b1; keys[14] = 1'b1; keys[26] = 1'b1; ear = 1'b0;
    do_read(16'hDEFE);
    check("R9 example", {8'd0, dout}, 16'h001C);
    check("R2 unscanned row", {8'd0, dout}, {8'd0, model_read(keys, 16'hDEFE, 1'b0)});
    idle_bus();
  endtask

  task automatic t_rows();
    // One key per row, each row alone
    for (int k = 0; k < 8; k++) begin
      keys = '0; keys[k*5 + (k % 5)] = 1'b1; keys[((k+1)%8)*5 + 2] = 1'b1;
      do_read(~(16'h0100 << k) & 16'hFF00 | 16'h00FE);
      check("R2 single row", {8'd0, dout}, {8'd0, model_read(keys, addr, ear)});
    end
    // Several rows merged
    keys = 40'h84_2108_4210;
    do_read(16'h00FE);
    check("R3 all rows", {8'd0, dout}, {8'd0, model_read(keys, 16'h00FE, ear)});
    do_read(16'h5AFE);
    check("R3 mixed rows", {8'd0, dout}, {8'd0, model_read(keys, 16'h5AFE, ear)});
    keys = '1;
    do_read(16'hFFFE);
    check("R3 none scanned", {8'd0, dout}, 16'h001F);
    idle_bus();
  endtask

  task automatic t_ear();
    keys = '0; ear = 1'b1;
    do_read(16'h7FFE);
    check("R4 ear high", {8'd0, dout}, 16'h005F);
    ear = 1'b0;
    #1;
    check("R4 ear low", {8'd0, dout}, 16'h001F);
    idle_bus();
  endtask

  task automatic t_decode();
    keys = '0; keys[3] = 1'b1;
    do_read(16'hFE80);
    check("R1 low bits ignored", {7'd0, dout_valid, dout}, {8'h01, 8'h17});
    do_read(16'hFEFF);
    check("R1 odd address", {7'd0, dout_valid, dout}, 16'h00FF);
    @(negedge clk); addr = 16'hFEFE; iorq_n = 1'b1; rd_n = 1'b0; #2;
    check("R5 no iorq", {7'd0, dout_valid, dout}, 16'h00FF);
    @(negedge clk); iorq_n = 1'b0; rd_n = 1'b1; #2;
    check("R5 no rd", {7'd0, dout_valid, dout}, 16'h00FF);
    idle_bus();
  endtask

  task automatic t_write();
    do_write(16'h12FE, 8'hFD, 1'b0, 1'b0);
    check("R6 write fd", {11'd0, border, mic, spk}, {11'd0, 3'd5, 1'b1, 1'b1});
    do_write(16'hA502, 8'hE2, 1'b0, 1'b0);
    check("R6 write e2", {11'd0, border, mic, spk}, {11'd0, 3'd2, 1'b0, 1'b0});
    do_write(16'h0013, 8'h1F, 1'b0, 1'b0);
    check("R7 odd addr", {11'd0, border, mic, spk}, {11'd0, 3'd2, 1'b0, 1'b0});
    do_write(16'h00FE, 8'h1F, 1'b1, 1'b0);
    check("R7 no iorq", {11'd0, border, mic, spk}, {11'd0, 3'd2, 1'b0, 1'b0});
    do_write(16'h00FE, 8'h1F, 1'b0, 1'b1);
    check("R7 no wr", {11'd0, border, mic, spk}, {11'd0, 3'd2, 1'b0, 1'b0});
  endtask

  task automatic t_concurrent();
    keys = '0; keys[9] = 1'b1; keys[35] = 1'b1; ear = 1'b1;
    @(negedge clk);
    addr = 16'h7EFE; din = 8'h0F; iorq_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0;
    #2;
    check("R3 read during write", {8'd0, dout}, {8'd0, model_read(keys, 16'h7EFE, 1'b1)});
    @(posedge clk); #2;
    check("R6 write during read", {11'd0, border, mic, spk}, {11'd0, 3'd7, 1'b1, 1'b0});
    idle_bus();
  endtask

  task automatic t_reset_again();
    @(negedge clk); rst_n = 1'b0; #2;
    check("R8 reset clears", {11'd0, border, mic, spk}, 16'd0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_example();
    t_rows();
    t_ear();
    t_decode();
    t_write();
    t_concurrent();
    t_reset_again();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule